// File: doc/BRIEF.md
# CAN Controller Operating Mode Manager

This block holds the master control word of a CAN controller and sequences the controller through its operating modes: sleep, freeze (used for configuration), normal operation and bus-off. Software reaches the control word through a single-register write port and a read-back port. The sequencer watches three things on the bus side: a start-of-frame indication, a strobe that marks a detected bus-off recovery sequence, and the bus-off flag from the error-counting logic. It also watches a debug-pause input from the chip's debug logic.

Sleep can end in two ways. Software can clear the sleep request, or hardware can end sleep on bus activity when the wake-on-activity bit is set. Bus-off can also end in two ways. In automatic mode it ends on the first recovery sequence. In software mode the controller must first pass through freeze and out again, and the next recovery sequence then ends bus-off. A write-1-to-set partial reset returns the control word to its reset value, pulses a reset to the receive FIFO and forces sleep, and then clears itself. The block passes the policy bits straight to the receive FIFO and the transmit arbiter: overflow drop rule, transmit ordering, retransmission disable and time-triggered mode.

Top module: `canmode_ctrl`

## Requirements
- R1: The control word reads 0x0001_0002 after reset. Bits 31:17 and 14:8 always read 0, and writes to them have no effect.
- R2: Bits 16 and 7:0 are read/write. The policy outputs follow the stored bits: bit 3 drives ovf_drop_new_o (1 = drop the incoming message), bit 2 drives tx_req_order_o (1 = request order, 0 = lowest identifier), bit 4 drives no_retx_o, and bit 7 drives ttc_en_o.
- R3: tx_en_o is 1 only when the mode is normal and bits 16 and dbg_pause_i are not both 1.
- R4: A write with bit 15 set has four effects. At that edge the control word loads its reset value. Bit 15 then reads 1 and rxfifo_rst_o is 1 for exactly one cycle. Bit 15 then clears itself. The mode is sleep on the cycle after the write edge.
- R5: A write made in the cycle when bit 15 reads 1 is ignored.
- R6: mode_o encodes normal=00, sleep=01, freeze=10 and bus-off=11. The mode is registered from the previous cycle's state, in priority order: partial reset, sleep request (bit 1), freeze request (bit 0), bus-off, normal. The mode is sleep after reset.
- R7: Auto wake. When bit 5 is 1 and the mode is sleep, a bus_sof_i pulse clears bit 1 at that edge, and the mode leaves sleep on the next edge.
- R8: When bit 5 is 0, bus_sof_i has no effect on bit 1 or on the mode. Sleep ends only through a software write.
- R9: bus_off_i high in normal mode latches bus-off. mode_o reads 11 from the second edge onward.
- R10: When bit 6 is 1, a bo_exit_seq_i pulse during bus-off ends it. The mode reads normal two edges later if no request bit is set.
- R11: When bit 6 is 0, bo_exit_seq_i is ignored until the mode has entered and then left freeze during bus-off. The next pulse after that ends bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Control word read-back |
| bus_sof_i | input | 1 | Start of frame seen on the bus |
| bo_exit_seq_i | input | 1 | Bus-off recovery sequence detected |
| bus_off_i | input | 1 | Bus-off flag from error counting |
| dbg_pause_i | input | 1 | Debug pause request |
| mode_o | output | 2 | Current operating mode |
| tx_en_o | output | 1 | Transmit enable gate |
| rxfifo_rst_o | output | 1 | Receive FIFO reset pulse |
| ovf_drop_new_o | output | 1 | FIFO overflow drops the new message |
| tx_req_order_o | output | 1 | Transmit in request order |
| no_retx_o | output | 1 | Automatic retransmission disabled |
| ttc_en_o | output | 1 | Time-triggered mode enable |

## Verification
A wrong bus-off latch or a wrong freeze-seen flag shows up at mode_o as early bus-off recovery or as no recovery at all. That error appears one edge after the relevant recovery pulse. A stuck partial-reset flag shows up at once as a second rxfifo_rst_o cycle, a bit 15 that stays set, and writes that are dropped. A bench model updated on every edge compares mode_o, tx_en_o, read-back and every policy output on every cycle. Any divergence is therefore reported in the cycle it first appears.

// File: rtl/canmode_pkg.sv
package canmode_pkg;

    localparam int CTRL_W     = 32;
    localparam int MODE_W     = 2;

    localparam int B_FREEZE   = 0;
    localparam int B_SLEEP    = 1;
    localparam int B_TXORD    = 2;
    localparam int B_OVFNEW   = 3;
    localparam int B_NORETX   = 4;
    localparam int B_AUTOWAKE = 5;
    localparam int B_AUTOBO   = 6;
    localparam int B_TTC      = 7;
    localparam int B_PRST     = 15;
    localparam int B_DBGTX    = 16;

    localparam logic [CTRL_W-1:0] RW_MASK =
        (CTRL_W'(1) << B_DBGTX) | CTRL_W'(32'h0000_00FF);
    localparam logic [CTRL_W-1:0] RST_VAL =
        (CTRL_W'(1) << B_DBGTX) | (CTRL_W'(1) << B_SLEEP);

    typedef enum logic [MODE_W-1:0] {
        MODE_NORMAL = 2'b00,
        MODE_SLEEP  = 2'b01,
        MODE_FREEZE = 2'b10,
        MODE_BUSOFF = 2'b11
    } mode_e;

    typedef struct packed {
        logic ttc;
        logic no_retx;
        logic ovf_drop_new;
        logic tx_req_order;
    } policy_t;

    function automatic mode_e pick_mode(input logic busy, input logic slp,
                                        input logic frz, input logic bo);
        if (busy)      return MODE_SLEEP;
        else if (slp)  return MODE_SLEEP;
        else if (frz)  return MODE_FREEZE;
        else if (bo)   return MODE_BUSOFF;
        else           return MODE_NORMAL;
    endfunction

    function automatic policy_t extract_policy(input logic [CTRL_W-1:0] w);
        policy_t p;
        p.ttc          = w[B_TTC];
        p.no_retx      = w[B_NORETX];
        p.ovf_drop_new = w[B_OVFNEW];
        p.tx_req_order = w[B_TXORD];
        return p;
    endfunction

endpackage

// File: rtl/canmode_regfile.sv
module canmode_regfile
    import canmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  mode_e             mode_i,
    input  logic              bus_act_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              busy_o
);

    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic              busy_q, busy_d;
    logic              wake_clr;

    assign wake_clr = (mode_i == MODE_SLEEP) && ctrl_q[B_AUTOWAKE] && bus_act_i;

    always_comb begin
        ctrl_d = ctrl_q;
        busy_d = 1'b0;
        if (!busy_q) begin
            if (wr_en && wdata[B_PRST]) begin
                ctrl_d = RST_VAL;
                busy_d = 1'b1;
            end else begin
                if (wr_en) ctrl_d = wdata & RW_MASK;
                if (wake_clr) ctrl_d[B_SLEEP] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RST_VAL;
            busy_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            busy_q <= busy_d;
        end
    end

    assign ctrl_o = ctrl_q;
    assign busy_o = busy_q;

    assert_prst_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !busy_q);

    assert_prst_loads_default_R4: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ctrl_q == RST_VAL);

    assert_wr_ignored_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && wr_en) |=> ctrl_q == RST_VAL);

    assert_no_wake_manual_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SLEEP && !ctrl_q[B_AUTOWAKE] && !wr_en && !busy_q)
        |=> $stable(ctrl_q[B_SLEEP]));

endmodule

// File: rtl/canmode_busoff.sv
module canmode_busoff
    import canmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode_q,
    input  mode_e mode_d,
    input  logic  bus_off_i,
    input  logic  exit_seq_i,
    input  logic  auto_exit_i,
    output logic  bo_o
);

    logic bo_q, fseen_q;
    logic leave_bo, enter_bo, frz_exit;

    assign leave_bo = bo_q && exit_seq_i && (auto_exit_i || fseen_q);
    assign enter_bo = (mode_q == MODE_NORMAL) && bus_off_i;
    assign frz_exit = (mode_q == MODE_FREEZE) && (mode_d != MODE_FREEZE);

    always_ff @(posedge clk) begin
        if (rst) begin
            bo_q    <= 1'b0;
            fseen_q <= 1'b0;
        end else begin
            if (leave_bo) begin
                bo_q    <= 1'b0;
                fseen_q <= 1'b0;
            end else begin
                if (enter_bo) bo_q <= 1'b1;
                if (frz_exit && bo_q) fseen_q <= 1'b1;
            end
        end
    end

    assign bo_o = bo_q;

    assert_bo_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORMAL && bus_off_i) |=> bo_q);

    assert_bo_manual_needs_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(bo_q) && !$past(auto_exit_i)) |-> $past(fseen_q));

    assert_bo_exit_on_seq_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(bo_q) |-> $past(exit_seq_i));

endmodule

// File: rtl/canmode_fsm.sv
module canmode_fsm
    import canmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy_i,
    input  logic  sleep_req_i,
    input  logic  freeze_req_i,
    input  logic  bo_i,
    output mode_e mode_q,
    output mode_e mode_d
);

    assign mode_d = pick_mode(busy_i, sleep_req_i, freeze_req_i, bo_i);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_SLEEP;
        else     mode_q <= mode_d;
    end

    assert_prst_forces_sleep_R4: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> mode_q == MODE_SLEEP);

    assert_sleep_priority_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_req_i |=> mode_q == MODE_SLEEP);

    assert_freeze_priority_R6: assert property (@(posedge clk) disable iff (rst)
        (freeze_req_i && !sleep_req_i && !busy_i) |=> mode_q == MODE_FREEZE);

endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl
    import canmode_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic        bus_sof_i,
    input  logic        bo_exit_seq_i,
    input  logic        bus_off_i,
    input  logic        dbg_pause_i,
    output logic [1:0]  mode_o,
    output logic        tx_en_o,
    output logic        rxfifo_rst_o,
    output logic        ovf_drop_new_o,
    output logic        tx_req_order_o,
    output logic        no_retx_o,
    output logic        ttc_en_o
);

    logic [CTRL_W-1:0] ctrl;
    logic              busy;
    logic              bo;
    mode_e             mode_q, mode_d;
    policy_t           pol;

    canmode_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_i),
        .wdata     (reg_wdata_i),
        .mode_i    (mode_q),
        .bus_act_i (bus_sof_i),
        .ctrl_o    (ctrl),
        .busy_o    (busy)
    );

    canmode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .busy_i       (busy),
        .sleep_req_i  (ctrl[B_SLEEP]),
        .freeze_req_i (ctrl[B_FREEZE]),
        .bo_i         (bo),
        .mode_q       (mode_q),
        .mode_d       (mode_d)
    );

    canmode_busoff u_bo (
        .clk         (clk),
        .rst         (rst),
        .mode_q      (mode_q),
        .mode_d      (mode_d),
        .bus_off_i   (bus_off_i),
        .exit_seq_i  (bo_exit_seq_i),
        .auto_exit_i (ctrl[B_AUTOBO]),
        .bo_o        (bo)
    );

    always_comb begin
        reg_rdata_o         = ctrl;
        reg_rdata_o[B_PRST] = busy;
    end

    assign pol            = extract_policy(ctrl);
    assign mode_o         = mode_q;
    assign tx_en_o        = (mode_q == MODE_NORMAL) && !(ctrl[B_DBGTX] && dbg_pause_i);
    assign rxfifo_rst_o   = busy;
    assign ovf_drop_new_o = pol.ovf_drop_new;
    assign tx_req_order_o = pol.tx_req_order;
    assign no_retx_o      = pol.no_retx;
    assign ttc_en_o       = pol.ttc;

    assert_tx_only_normal_R3: assert property (@(posedge clk) disable iff (rst)
        tx_en_o |-> mode_o == MODE_NORMAL);

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o & ~(RW_MASK | (CTRL_W'(1) << B_PRST))) == '0);

    assert_fifo_rst_single_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rxfifo_rst_o) |=> !rxfifo_rst_o);

endmodule

// File: tb/canmode_ctrl_bench.sv
module canmode_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] reg_rdata_o;
    logic        bus_sof_i, bo_exit_seq_i, bus_off_i, dbg_pause_i;
    logic [1:0]  mode_o;
    logic        tx_en_o, rxfifo_rst_o, ovf_drop_new_o, tx_req_order_o, no_retx_o, ttc_en_o;

    always #10 clk = ~clk;

    canmode_ctrl u_canmode_ctrl (.*);

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_ctrl;
    logic        m_busy, m_bo, m_fseen;
    logic [1:0]  m_mode;

    localparam logic [1:0] MN = 2'b00, MS = 2'b01, MF = 2'b10, MB = 2'b11;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_mode_next();
        if (m_busy || m_ctrl[1]) return MS;
        if (m_ctrl[0])           return MF;
        if (m_bo)                return MB;
        return MN;
    endfunction

    task automatic model_edge();
        logic [31:0] c_n;
        logic        busy_n, bo_n, fs_n;
        logic [1:0]  mode_n;
        mode_n = ref_mode_next();
        bo_n = m_bo; fs_n = m_fseen;
        if (m_bo && bo_exit_seq_i && (m_ctrl[6] || m_fseen)) begin
            bo_n = 0; fs_n = 0;
        end else begin
            if (m_mode == MN && bus_off_i) bo_n = 1;
            if (m_mode == MF && mode_n != MF && m_bo) fs_n = 1;
        end
        c_n = m_ctrl; busy_n = 0;
        if (!m_busy) begin
            if (reg_wr_i && reg_wdata_i[15]) begin
                c_n = 32'h0001_0002; busy_n = 1;
            end else begin
                if (reg_wr_i) c_n = reg_wdata_i & 32'h0001_00FF;
                if (m_mode == MS && m_ctrl[5] && bus_sof_i) c_n[1] = 0;
            end
        end
        if (rst) begin
            c_n = 32'h0001_0002; busy_n = 0; bo_n = 0; fs_n = 0; mode_n = MS;
        end
        m_ctrl = c_n; m_busy = busy_n; m_bo = bo_n; m_fseen = fs_n; m_mode = mode_n;
    endtask

    task automatic compare_all();
        check("rdata", reg_rdata_o, m_ctrl | (32'(m_busy) << 15));
        check("mode", 32'(mode_o), 32'(m_mode));
        check("tx_en", 32'(tx_en_o), 32'(m_mode == MN && !(m_ctrl[16] && dbg_pause_i)));
        check("fifo_rst", 32'(rxfifo_rst_o), 32'(m_busy));
        check("policy", {28'd0, ttc_en_o, no_retx_o, ovf_drop_new_o, tx_req_order_o},
              {28'd0, m_ctrl[7], m_ctrl[4], m_ctrl[3], m_ctrl[2]});
    endtask

    // one clock: inputs already driven; model follows edge; compare at negedge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        reg_wr_i = 0; bus_sof_i = 0; bo_exit_seq_i = 0; bus_off_i = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_i = 1; reg_wdata_i = d; cyc();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; reg_wr_i = 0; reg_wdata_i = 0; bus_sof_i = 0;
        bo_exit_seq_i = 0; bus_off_i = 0; dbg_pause_i = 0;
        m_ctrl = 0; m_busy = 0; m_bo = 0; m_fseen = 0; m_mode = MS;
        cyc(); cyc();
        rst = 0;
        // R1: reset state
        cur_req = "R1";
        check("reset rdata R1", reg_rdata_o, 32'h0001_0002);
        check("reset mode R6", 32'(mode_o), 32'(MS));
        wr(32'hFFFF_7FFF); idle(1);
        check("reserved bits R1", reg_rdata_o, 32'h0001_00FF);
        // R2: policy bits
        cur_req = "R2";
        wr(32'h0000_0014); idle(1);
        check("no_retx R2", 32'(no_retx_o), 1);
        wr(32'h0000_0088); idle(1);
        check("ovf/ttc R2", {30'd0, ttc_en_o, ovf_drop_new_o}, 32'h3);
        // R3: debug transmit gate
        cur_req = "R3";
        wr(32'h0000_0000); dbg_pause_i = 1; idle(2);
        check("tx with ptd=0 R3", 32'(tx_en_o), 1);
        wr(32'h0001_0000); idle(1);
        check("tx blocked R3", 32'(tx_en_o), 0);
        dbg_pause_i = 0; idle(1);
        check("tx resumed R3", 32'(tx_en_o), 1);
        // R6: priority
        cur_req = "R6";
        wr(32'h0000_0003); idle(1);
        check("sleep over freeze R6", 32'(mode_o), 32'(MS));
        wr(32'h0000_0001); idle(1);
        check("freeze R6", 32'(mode_o), 32'(MF));
        // R8: manual wake
        cur_req = "R8";
        wr(32'h0000_0002); idle(1);
        bus_sof_i = 1; cyc(); idle(1);
        check("sof ignored R8", 32'(mode_o), 32'(MS));
        wr(32'h0000_0000); idle(1);
        check("sw wake R8", 32'(mode_o), 32'(MN));
        // R7: auto wake
        cur_req = "R7";
        wr(32'h0000_0022); idle(1);
        bus_sof_i = 1; cyc();
        check("sleep bit cleared R7", reg_rdata_o, 32'h0000_0020);
        idle(1);
        check("auto wake R7", 32'(mode_o), 32'(MN));
        // R9 / R11: manual bus-off recovery
        cur_req = "R9";
        wr(32'h0000_0000); idle(1);
        bus_off_i = 1; cyc(); idle(1);
        check("bus-off entered R9", 32'(mode_o), 32'(MB));
        cur_req = "R11";
        bo_exit_seq_i = 1; cyc(); idle(1);
        check("exit ignored R11", 32'(mode_o), 32'(MB));
        wr(32'h0000_0001); idle(1);
        bo_exit_seq_i = 1; cyc(); idle(1);
        wr(32'h0000_0000); idle(1);
        check("after freeze R11", 32'(mode_o), 32'(MB));
        bo_exit_seq_i = 1; cyc(); idle(1);
        check("manual recovery R11", 32'(mode_o), 32'(MN));
        // R10: automatic recovery
        cur_req = "R10";
        wr(32'h0000_0040); idle(1);
        bus_off_i = 1; cyc(); idle(1);
        bo_exit_seq_i = 1; cyc(); idle(1);
        check("auto recovery R10", 32'(mode_o), 32'(MN));
        // R4 / R5: partial reset
        cur_req = "R4";
        wr(32'h0000_8040);
        check("prst flag R4", reg_rdata_o, 32'h0001_8002);
        check("fifo pulse R4", 32'(rxfifo_rst_o), 1);
        cur_req = "R5";
        wr(32'h0000_0000);
        check("write ignored R5", reg_rdata_o, 32'h0001_0002);
        cur_req = "R4";
        check("prst forces sleep R4", 32'(mode_o), 32'(MS));
        check("fifo pulse ends R4", 32'(rxfifo_rst_o), 0);
        wr(32'h0000_0000); idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule